// File: doc/BRIEF.md
# Lockable Write-Through Line Cache

This block is a 256-byte cache that sits between a processor core and a slower memory port. The storage holds 16 lines of 16 bytes. The core issues word accesses with a request/ready handshake, and the memory side answers one 32-bit beat per `mem_ready` pulse. A two-bit policy field chooses whether data accesses, instruction accesses, both or neither are cached. Each access also carries a non-cacheable flag, which sends it straight to memory.

Lookup is fully associative. A read miss loads the whole line in four ascending beats and then returns the requested word. Every store is written through to memory, and any resident copy is updated in place. A store miss does not allocate a line. A line can be locked by number so that it is never evicted. A global invalidate input clears every unlocked line. A scratchpad switch turns the storage into directly addressed RAM with one-cycle access and no tag check.

The victim is the lowest-numbered free unlocked line. When no such line exists, the victim is the next unlocked line at or after a round-robin pointer. If every line is locked, a read miss is served uncached.

Top module: `lockable_wt_cache`

## Requirements
- R1: After reset `core_ready` and `mem_req` are low and every line is invalid, so the first cacheable read misses.
- R2: `cfg_mode` bit 0 enables caching of data accesses (`core_instr`=0) and bit 1 enables caching of instruction accesses (`core_instr`=1). An access whose kind is not enabled is read with one memory beat at its own word address, does not allocate a line and is not served from a resident line.
- R3: A cacheable read hit returns the stored word with `core_ready` high in the cycle after the request is taken, and it causes no memory traffic.
- R4: A cacheable read miss reads four beats at byte offsets 0, 4, 8 and 12 of the line. `core_ready` rises in the cycle after the last beat with the addressed word, and the line is resident from then on.
- R5: When scratchpad mode is off, every store makes exactly one memory write of its address and data, and `core_ready` follows the write's `mem_ready`. A resident copy is updated. A store miss does not allocate a line.
- R6: A read with `core_nc`=1 uses one memory beat. It is never served from a resident line and never allocates one.
- R7: With `cfg_scratch`=1, address bits [7:4] select the line and bits [3:2] select the word. Reads and writes complete in the cycle after the request and cause no memory traffic.
- R8: Writing `lock_val` to line `lock_idx` with `lock_we` sets or clears that line's lock. A locked line is never chosen as a victim.
- R9: A fill goes to the lowest-numbered invalid unlocked line. When no such line exists, it goes to the first unlocked line at or after a round-robin pointer, and the pointer then moves past that line. The pointer starts at line 0 after reset.
- R10: A pulse on `inval_all` invalidates every unlocked line, and locked lines stay resident.
- R11: When all lines are locked, a cacheable read miss is served with one uncached beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Caching policy: bit0 data, bit1 instruction |
| cfg_scratch | input | 1 | Scratchpad RAM mode |
| inval_all | input | 1 | Invalidate all unlocked lines |
| lock_we | input | 1 | Lock bit write strobe |
| lock_idx | input | 4 | Line number for lock write |
| lock_val | input | 1 | Lock value to write |
| core_req | input | 1 | Core access request, held until ready |
| core_we | input | 1 | Access is a store |
| core_instr | input | 1 | Access is an instruction fetch |
| core_nc | input | 1 | Access is non-cacheable |
| core_addr | input | 32 | Byte address (word aligned) |
| core_wdata | input | 32 | Store data |
| core_ready | output | 1 | Access complete, one-cycle pulse |
| core_rdata | output | 32 | Read data, valid with core_ready |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory beat accepted / read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Hits and scratchpad accesses are due one cycle after the request is taken. A fill is due one cycle after its fourth accepted beat, and an uncached read or a store is due one cycle after its single accepted beat. The bench raises a request at a falling edge and counts falling edges until `core_ready` is seen. It requires a count of exactly one for hits and scratchpad accesses. For every access it also counts the read and write beats the memory model accepts, and residency and victim placement are judged from those counts and from scratchpad reads of the storage.

// File: rtl/lwc_pkg.sv
// Shared types for the lockable write-through cache.
package lwc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYP,
        ST_WR,
        ST_DONE
    } lwc_state_t;
endpackage

// File: rtl/lwc_tag_store.sv
// Tag, valid and lock state for a fully associative cache; hit lookup and
// victim choice. Assumes LINES is a power of two and that lock bits are not
// changed while a fill is in flight.
module lwc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 28,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lookup_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             victim_ok,
    output logic [IDX_W-1:0] victim_idx,
    input  logic             inv,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic             lock_val,
    input  logic             install_en,
    input  logic [IDX_W-1:0] install_idx,
    input  logic [TAG_W-1:0] install_tag
);
    logic [LINES-1:0] valid;
    logic [LINES-1:0] lock;
    logic [TAG_W-1:0] tags [LINES];
    logic [IDX_W-1:0] rr;
    logic [LINES-1:0] hit_vec;
    logic [LINES-1:0] free;
    logic [IDX_W-1:0] pos;
    logic             found;

    // Compare the lookup tag against every valid line.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == lookup_tag);
    end

    // Encode the matching line number.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++)
            if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
    assign hit = |hit_vec;

    // Choose a victim: lowest free unlocked line, else round-robin among unlocked.
    assign free      = ~valid & ~lock;
    assign victim_ok = |(~lock);
    always_comb begin
        victim_idx = '0;
        found      = 1'b0;
        pos        = '0;
        for (int i = LINES - 1; i >= 0; i--)
            if (free[i]) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        if (!found)
            for (int i = LINES - 1; i >= 0; i--) begin
                pos = rr + IDX_W'(i);
                if (!lock[pos]) victim_idx = pos;
            end
    end

    // Maintain valid bits, lock bits and the round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            lock  <= '0;
            rr    <= '0;
        end else begin
            if (lock_we) lock[lock_idx] <= lock_val;
            if (inv) valid <= valid & lock;
            if (install_en) begin
                valid[install_idx] <= 1'b1;
                if (valid[install_idx]) rr <= install_idx + 1'b1;
            end
        end
    end

    // Record the tag of a freshly filled line.
    always_ff @(posedge clk) begin
        if (install_en) tags[install_idx] <= install_tag;
    end

    // R1: no line is valid right after reset.
    a_r1_all_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (valid == '0));
    // R8: a fill never lands on a locked line.
    a_r8_no_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
        install_en |-> !lock[install_idx]);
    // R10: after an invalidate, only lines that were locked remain valid.
    a_r10_inv_keeps_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv) && !$past(install_en)) |-> ((valid & ~$past(lock)) == '0));
endmodule

// File: rtl/lwc_data_store.sv
// Word-addressed line storage: one combinational read port, one synchronous
// write port. Contents are not reset.
module lwc_data_store #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem [WORDS];

    assign rd_data = mem[rd_idx];

    // Store one word per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/lockable_wt_cache.sv
// Fully associative write-through cache with a per-kind caching policy,
// scratchpad mode, line locking and a non-cacheable bypass. Assumes
// word-aligned accesses and that core_req is held until core_ready.
module lockable_wt_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_mode,
    input  logic                     cfg_scratch,
    input  logic                     inval_all,
    input  logic                     lock_we,
    input  logic [$clog2(LINES)-1:0] lock_idx,
    input  logic                     lock_val,
    input  logic                     core_req,
    input  logic                     core_we,
    input  logic                     core_instr,
    input  logic                     core_nc,
    input  logic [ADDR_W-1:0]        core_addr,
    input  logic [DATA_W-1:0]        core_wdata,
    output logic                     core_ready,
    output logic [DATA_W-1:0]        core_rdata,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_ready,
    input  logic [DATA_W-1:0]        mem_rdata
);
    import lwc_pkg::*;

    localparam int IDX_W  = $clog2(LINES);
    localparam int WBYTES = DATA_W / 8;
    localparam int WB_W   = $clog2(WBYTES);
    localparam int WORDS  = LINE_BYTES / WBYTES;
    localparam int WOFF_W = $clog2(WORDS);
    localparam int BOFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - BOFF_W;
    localparam int SA_W   = IDX_W + WOFF_W;

    lwc_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [WOFF_W-1:0] beat;
    logic [IDX_W-1:0]  victim_q;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              victim_ok;
    logic [IDX_W-1:0]  victim_idx;
    logic              cacheable;
    logic              take;
    logic              install_en;
    logic [SA_W-1:0]   rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [SA_W-1:0]   wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [WOFF_W-1:0] req_word;

    assign take       = (state == ST_IDLE) && core_req;
    assign cacheable  = !core_nc && (core_instr ? cfg_mode[1] : cfg_mode[0]);
    assign req_word   = core_addr[BOFF_W-1:WB_W];
    assign install_en = (state == ST_FILL) && mem_ready && (beat == WOFF_W'(WORDS - 1));

    lwc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_tag (core_addr[ADDR_W-1:BOFF_W]),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .victim_ok  (victim_ok),
        .victim_idx (victim_idx),
        .inv        (inval_all),
        .lock_we    (lock_we),
        .lock_idx   (lock_idx),
        .lock_val   (lock_val),
        .install_en (install_en),
        .install_idx(victim_q),
        .install_tag(addr_q[ADDR_W-1:BOFF_W])
    );

    lwc_data_store #(.WORDS(LINES * WORDS), .DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

    // Storage read index: direct in scratchpad mode, matching line otherwise.
    assign rd_idx = cfg_scratch ? core_addr[SA_W+WB_W-1:WB_W] : {hit_idx, req_word};

    // Storage write port: scratchpad/hit store from the core, or a fill beat.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = rd_idx;
        wr_data = core_wdata;
        if (take && core_we && (cfg_scratch || hit)) begin
            wr_en = 1'b1;
        end else if ((state == ST_FILL) && mem_ready) begin
            wr_en   = 1'b1;
            wr_idx  = {victim_q, beat};
            wr_data = mem_rdata;
        end
    end

    // Access sequencer: classify, fill, bypass, write through, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            beat     <= '0;
            victim_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (core_req) begin
                    addr_q  <= core_addr;
                    wdata_q <= core_wdata;
                    beat    <= '0;
                    if (cfg_scratch) begin
                        if (!core_we) rdata_q <= rd_data;
                        state <= ST_DONE;
                    end else if (core_we) begin
                        state <= ST_WR;
                    end else if (cacheable && hit) begin
                        rdata_q <= rd_data;
                        state   <= ST_DONE;
                    end else if (cacheable && victim_ok) begin
                        victim_q <= victim_idx;
                        state    <= ST_FILL;
                    end else begin
                        state <= ST_BYP;
                    end
                end
                ST_FILL: if (mem_ready) begin
                    beat <= beat + 1'b1;
                    if (beat == addr_q[BOFF_W-1:WB_W]) rdata_q <= mem_rdata;
                    if (beat == WOFF_W'(WORDS - 1)) state <= ST_DONE;
                end
                ST_BYP: if (mem_ready) begin
                    rdata_q <= mem_rdata;
                    state   <= ST_DONE;
                end
                ST_WR: if (mem_ready) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory beat address: walk the line during a fill, else the access word.
    always_comb begin
        mem_addr = {addr_q[ADDR_W-1:WB_W], {WB_W{1'b0}}};
        if (state == ST_FILL)
            mem_addr = {addr_q[ADDR_W-1:BOFF_W], beat, {WB_W{1'b0}}};
    end

    assign mem_req    = (state == ST_FILL) || (state == ST_BYP) || (state == ST_WR);
    assign mem_we     = (state == ST_WR);
    assign mem_wdata  = wdata_q;
    assign core_ready = (state == ST_DONE);
    assign core_rdata = rdata_q;

    // R1: both handshake outputs are idle right after reset.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!core_ready && !mem_req));
    // R3: a cacheable read hit answers next cycle without memory traffic.
    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !core_we && !cfg_scratch && cacheable && hit) |=> (core_ready && !mem_req));
    // R4: the response follows the last fill beat.
    a_r4_ready_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        install_en |=> core_ready);
    // R5: a store outside scratchpad mode becomes a memory write.
    a_r5_store_written: assert property (@(posedge clk) disable iff (!rst_n)
        (take && core_we && !cfg_scratch) |=> (mem_req && mem_we));
    // R6: a non-cacheable access never starts a fill.
    a_r6_nc_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (take && core_nc && !cfg_scratch) |=> (state != ST_FILL));
    // R7: scratchpad accesses finish next cycle with no memory request.
    a_r7_scratch_local: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg_scratch) |=> (core_ready && !mem_req));
    // R11: with every line locked a read miss does not fill.
    a_r11_all_locked_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !core_we && !cfg_scratch && !victim_ok) |=> (state != ST_FILL));
endmodule

// File: tb/lockable_wt_cache_test.sv
module lockable_wt_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b11;
    logic        cfg_scratch = 1'b0;
    logic        inval_all = 1'b0;
    logic        lock_we = 1'b0;
    logic [3:0]  lock_idx = '0;
    logic        lock_val = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic        core_instr = 1'b0;
    logic        core_nc = 1'b0;
    logic [31:0] core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_ready;
    logic [31:0] core_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    bit finished = 1'b0;
    logic [31:0] model [256];
    logic [31:0] ref_mem [256];

    always #5 clk = ~clk;

    lockable_wt_cache uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_scratch(cfg_scratch),
        .inval_all(inval_all), .lock_we(lock_we), .lock_idx(lock_idx), .lock_val(lock_val),
        .core_req(core_req), .core_we(core_we), .core_instr(core_instr), .core_nc(core_nc),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
        .core_rdata(core_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model: one beat every two cycles while requested.
    initial begin
        for (int i = 0; i < 256; i++) begin
            model[i]   = (32'(i) * 32'h0101_0101) ^ 32'h5A00_0000;
            ref_mem[i] = (32'(i) * 32'h0101_0101) ^ 32'h5A00_0000;
        end
        forever begin
            @(posedge clk);
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    model[mem_addr[9:2]] <= mem_wdata;
                    wr_beats++;
                end else begin
                    rd_beats++;
                end
            end
            mem_ready <= rst_n && mem_req && !mem_ready;
            mem_rdata <= model[mem_addr[9:2]];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One core access; returns read data, latency and memory beats used.
    task automatic access(input bit we, input bit instr, input bit nc, input logic [31:0] addr,
                          input logic [31:0] wdata, output logic [31:0] rd, output int lat,
                          output int rdb, output int wrb);
        int r0 = rd_beats;
        int w0 = wr_beats;
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_instr = instr; core_nc = nc;
        core_addr = addr; core_wdata = wdata;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!core_ready);
        rd = core_rdata;
        core_req = 1'b0; core_we = 1'b0;
        rdb = rd_beats - r0;
        wrb = wr_beats - w0;
        if (we && !cfg_scratch) ref_mem[addr[9:2]] = wdata;
    endtask

    task automatic set_lock(input int idx, input bit val);
        @(negedge clk);
        lock_we = 1'b1; lock_idx = 4'(idx); lock_val = val;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic        instr;
        logic        nc;
        logic [1:0]  mode;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  rdb;
        logic [3:0]  wrb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 2'b11, 32'h040, 32'h0, 4'd4, 4'd0, 4'd4},        // R4 R1 miss after reset
        '{1'b0, 1'b0, 1'b0, 2'b11, 32'h044, 32'h0, 4'd0, 4'd0, 4'd3},        // R3 hit
        '{1'b0, 1'b0, 1'b0, 2'b11, 32'h04C, 32'h0, 4'd0, 4'd0, 4'd3},        // R3 hit last word
        '{1'b1, 1'b0, 1'b0, 2'b11, 32'h048, 32'hDEAD0001, 4'd0, 4'd1, 4'd5}, // R5 store hit
        '{1'b0, 1'b0, 1'b0, 2'b11, 32'h048, 32'h0, 4'd0, 4'd0, 4'd5},        // R5 copy updated
        '{1'b1, 1'b0, 1'b0, 2'b11, 32'h100, 32'hBEEF0002, 4'd0, 4'd1, 4'd5}, // R5 store miss
        '{1'b0, 1'b0, 1'b0, 2'b11, 32'h100, 32'h0, 4'd4, 4'd0, 4'd5},        // R5 no allocate
        '{1'b0, 1'b1, 1'b0, 2'b01, 32'h200, 32'h0, 4'd1, 4'd0, 4'd2},        // R2 fetch not cached
        '{1'b0, 1'b1, 1'b0, 2'b01, 32'h200, 32'h0, 4'd1, 4'd0, 4'd2},        // R2 still not cached
        '{1'b0, 1'b1, 1'b0, 2'b10, 32'h200, 32'h0, 4'd4, 4'd0, 4'd2},        // R2 fetch cached
        '{1'b0, 1'b0, 1'b0, 2'b10, 32'h300, 32'h0, 4'd1, 4'd0, 4'd2},        // R2 data not cached
        '{1'b0, 1'b0, 1'b0, 2'b00, 32'h040, 32'h0, 4'd1, 4'd0, 4'd2},        // R2 off ignores resident
        '{1'b0, 1'b0, 1'b1, 2'b11, 32'h380, 32'h0, 4'd1, 4'd0, 4'd6},        // R6 bypass
        '{1'b0, 1'b0, 1'b0, 2'b11, 32'h380, 32'h0, 4'd4, 4'd0, 4'd6},        // R6 no allocate
        '{1'b0, 1'b0, 1'b1, 2'b11, 32'h044, 32'h0, 4'd1, 4'd0, 4'd6}         // R6 not served
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int lat, rdb, wrb;
        repeat (3) @(negedge clk);
        // R1: handshake outputs idle in reset and just after
        chk(!core_ready && !mem_req, "R1 idle in reset", {30'd0, core_ready, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!core_ready && !mem_req, "R1 idle after reset", {30'd0, core_ready, mem_req}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            cfg_mode = VEC[v].mode;
            access(VEC[v].we, VEC[v].instr, VEC[v].nc, VEC[v].addr, VEC[v].wdata, rd, lat, rdb, wrb);
            chk(rdb == int'(VEC[v].rdb), $sformatf("R%0d vec%0d read beats", VEC[v].req, v), rdb, VEC[v].rdb);
            chk(wrb == int'(VEC[v].wrb), $sformatf("R%0d vec%0d write beats", VEC[v].req, v), wrb, VEC[v].wrb);
            if (!VEC[v].we)
                chk(rd == ref_mem[VEC[v].addr[9:2]], $sformatf("R%0d vec%0d data", VEC[v].req, v), rd, ref_mem[VEC[v].addr[9:2]]);
            if (!VEC[v].we && VEC[v].rdb == 0)
                chk(lat == 1, $sformatf("R3 vec%0d hit latency", v), lat, 1);
        end
        chk(model[8'h12] == 32'hDEAD0001, "R5 memory holds stored word", model[8'h12], 32'hDEAD0001);

        // R9: fills so far went to lines 0..3 in order; look through scratchpad
        cfg_scratch = 1'b1;
        access(0, 0, 0, 32'h010, 0, rd, lat, rdb, wrb);
        chk(rd == ref_mem[8'h40], "R9 line1 holds 0x100", rd, ref_mem[8'h40]);
        access(0, 0, 0, 32'h030, 0, rd, lat, rdb, wrb);
        chk(rd == ref_mem[8'hE0], "R9 line3 holds 0x380", rd, ref_mem[8'hE0]);
        chk(lat == 1 && rdb == 0, "R7 scratch read latency", lat, 1);

        // R7: scratchpad write/read of line 15 word 1, no memory traffic
        access(1, 0, 0, 32'h0F4, 32'h1234_5678, rd, lat, rdb, wrb);
        chk(wrb == 0 && lat == 1, "R7 scratch write local", wrb, 0);
        access(0, 0, 0, 32'h0F4, 0, rd, lat, rdb, wrb);
        chk(rd == 32'h1234_5678, "R7 scratch readback", rd, 32'h1234_5678);
        cfg_scratch = 1'b0;
        cfg_mode = 2'b11;

        // R10 / R8: lock line 0 (holds 0x040), invalidate all
        set_lock(0, 1);
        pulse_inv();
        access(0, 0, 0, 32'h040, 0, rd, lat, rdb, wrb);
        chk(rdb == 0, "R10 locked line survives", rdb, 0);
        chk(rd == ref_mem[8'h10], "R10 locked line data", rd, ref_mem[8'h10]);
        access(0, 0, 0, 32'h100, 0, rd, lat, rdb, wrb);
        chk(rdb == 4, "R10 unlocked line cleared", rdb, 4);

        // R11: all lines locked, miss goes uncached twice
        for (int i = 0; i < 16; i++) set_lock(i, 1);
        access(0, 0, 0, 32'h1C0, 0, rd, lat, rdb, wrb);
        chk(rdb == 1, "R11 all locked bypass", rdb, 1);
        chk(rd == ref_mem[8'h70], "R11 bypass data", rd, ref_mem[8'h70]);
        access(0, 0, 0, 32'h1C0, 0, rd, lat, rdb, wrb);
        chk(rdb == 1, "R11 still not allocated", rdb, 1);

        // R9 / R8: fill all 16 lines, lock line 1, then two round-robin misses
        for (int i = 0; i < 16; i++) set_lock(i, 0);
        pulse_inv();
        for (int i = 0; i < 16; i++)
            access(0, 0, 0, 32'(i * 16), 0, rd, lat, rdb, wrb);
        set_lock(1, 1);
        access(0, 0, 0, 32'h200, 0, rd, lat, rdb, wrb);
        chk(rdb == 4, "R9 round-robin miss", rdb, 4);
        access(0, 0, 0, 32'h210, 0, rd, lat, rdb, wrb);
        access(0, 0, 0, 32'h010, 0, rd, lat, rdb, wrb);
        chk(rdb == 0, "R8 locked line kept", rdb, 0);
        cfg_scratch = 1'b1;
        access(0, 0, 0, 32'h000, 0, rd, lat, rdb, wrb);
        chk(rd == ref_mem[8'h80], "R9 first victim line0", rd, ref_mem[8'h80]);
        access(0, 0, 0, 32'h020, 0, rd, lat, rdb, wrb);
        chk(rd == ref_mem[8'h84], "R8 locked line1 skipped, victim line2", rd, ref_mem[8'h84]);
        access(0, 0, 0, 32'h010, 0, rd, lat, rdb, wrb);
        chk(rd == ref_mem[8'h04], "R8 line1 content intact", rd, ref_mem[8'h04]);
        cfg_scratch = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule